// File: doc/BRIEF.md
# Display Controller Extension Registers and Aperture Banking

This block holds the extension registers of a VGA-compatible display controller. It also turns host accesses through the 64 KB memory aperture into frame-buffer addresses. The host first loads an index through one port. It then reads or writes the register that index selects through a data port. Only the low three index bits are decoded, so the file spans eight slots.

Two slots hold registers:

- **Slot 3, the mode register.**
  - Bit 7 switches on the extended (linear) mode.
  - Bits 4:3 carry the video-delay code, which follows the installed memory size.
  - Bits 2:0 select the dot-clock divider.
- **Slot 4, the bank register.** It holds a 7-bit bank number.

With extended mode on, each aperture offset becomes `bank * 0x10000 + offset`. With it off, the block selects the legacy planar path and passes the offset through unchanged.

Top module: `crtx_ext_top`

## Requirements
- R1: After reset the index is 0, the mode and bank registers read 0x00, `ext_mode` is 0 and `legacy_sel` is 1.
- R2: Only index bits 2:0 are decoded. For example, index 0x0B reaches slot 3 and index 0xFC reaches slot 4.
- R3: With the index at 3, `dat_rdata` returns exactly the last byte written to slot 3.
- R4: `ext_mode` equals bit 7 of the mode register. It changes on the same clock edge that stores the register.
- R5: `vid_delay` presents mode-register bits 4:3 (00 = 4 MB board, 01 = 2 MB board, 1x = 8 MB board).
- R6: `clk_div` presents the divider for mode-register bits 2:0: 000→1, 001→2, 010→3, 011→4, 101→6, 111→8. Codes 100 and 110 are reserved; for them `clk_div` is 0 and `scale_err` is 1, while every valid code gives `scale_err` 0.
- R7: Slot 4 stores the low 7 bits of the written byte. It reads back with bit 7 as 0.
- R8: With `ext_mode` at 1, `lin_addr` = bank × 0x10000 + `ap_offset` and `legacy_sel` is 0.
- R9: With `ext_mode` at 0, `lin_addr` equals `ap_offset` zero-extended and `legacy_sel` is 1.
- R10: Slots 0–2 and 5–7 read 0x00. Writes to them leave the mode and bank registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Load the index register |
| idx_wdata | input | 8 | Index value (bits 2:0 decoded) |
| dat_we | input | 1 | Write the selected slot |
| dat_wdata | input | 8 | Data for the selected slot |
| dat_rdata | output | 8 | Read value of the selected slot |
| ap_offset | input | 16 | Host aperture offset |
| lin_addr | output | 23 | Resulting frame-buffer address |
| legacy_sel | output | 1 | Access goes to the legacy planar path |
| ext_mode | output | 1 | Extended linear mode enabled |
| vid_delay | output | 2 | Video-delay code |
| clk_div | output | 4 | Decoded dot-clock divider, 0 when reserved |
| scale_err | output | 1 | Reserved divider code present |

## Verification
The hardest case to reach is a bank register full of ones combined with an aperture offset at its top end while extended mode switches on. That combination shows whether bit 7 of the bank write is dropped and whether the bank lands above the offset with no carry. The stimulus writes 0xFF to slot 4, checks the legacy mapping, and then sets the mode bit. It samples in the first cycle after that edge. Aliased indices with high bits set then reach both registers again, and writes to empty slots are followed by readback of both live registers.

// File: rtl/crtx_pkg.sv
package crtx_pkg;
    localparam int IDX_W  = 3;
    localparam int BANK_W = 7;
    localparam int OFS_W  = 16;
    localparam int LIN_W  = BANK_W + OFS_W;
    localparam int DAT_W  = 8;

    localparam logic [IDX_W-1:0] SLOT_MODE = 3'd3;
    localparam logic [IDX_W-1:0] SLOT_BANK = 3'd4;

    // divider for a scale code; 0 marks a reserved code
    function automatic logic [3:0] scale_to_div(input logic [2:0] code);
        logic [3:0] d;
        unique case (code)
            3'b000:  d = 4'd1;
            3'b001:  d = 4'd2;
            3'b010:  d = 4'd3;
            3'b011:  d = 4'd4;
            3'b101:  d = 4'd6;
            3'b111:  d = 4'd8;
            default: d = 4'd0;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/crtx_regfile.sv
module crtx_regfile
    import crtx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_we,
    input  logic [DAT_W-1:0] idx_wdata,
    input  logic             dat_we,
    input  logic [DAT_W-1:0] dat_wdata,
    output logic [IDX_W-1:0] idx_q,
    output logic [DAT_W-1:0] mode_q,
    output logic [BANK_W-1:0] bank_q,
    output logic [DAT_W-1:0] rdata
);
    localparam int SLOTS = 1 << IDX_W;

    logic [SLOTS-1:0] slot_we;

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_dec
            assign slot_we[g] = dat_we && (idx_q == IDX_W'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_we) begin
            idx_q <= idx_wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (slot_we[SLOT_MODE]) begin
            mode_q <= dat_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (slot_we[SLOT_BANK]) begin
            bank_q <= dat_wdata[BANK_W-1:0];
        end
    end

    always_comb begin
        unique case (idx_q)
            SLOT_MODE: rdata = mode_q;
            SLOT_BANK: rdata = {{(DAT_W-BANK_W){1'b0}}, bank_q};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/crtx_mode_decode.sv
module crtx_mode_decode
    import crtx_pkg::*;
(
    input  logic [DAT_W-1:0] mode_q,
    output logic             ext_mode,
    output logic [1:0]       vid_delay,
    output logic [3:0]       clk_div,
    output logic             scale_err
);
    always_comb begin
        ext_mode  = mode_q[7];
        vid_delay = mode_q[4:3];
        clk_div   = scale_to_div(mode_q[2:0]);
        scale_err = (clk_div == 4'd0);
    end
endmodule

// File: rtl/crtx_aperture.sv
module crtx_aperture
    import crtx_pkg::*;
(
    input  logic              ext_mode,
    input  logic [BANK_W-1:0] bank_q,
    input  logic [OFS_W-1:0]  ap_offset,
    output logic [LIN_W-1:0]  lin_addr,
    output logic              legacy_sel
);
    always_comb begin
        legacy_sel = !ext_mode;
        if (ext_mode) begin
            lin_addr = {bank_q, ap_offset};
        end else begin
            lin_addr = {{BANK_W{1'b0}}, ap_offset};
        end
    end
endmodule

// File: rtl/crtx_ext_top.sv
module crtx_ext_top
    import crtx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_we,
    input  logic [7:0]       idx_wdata,
    input  logic             dat_we,
    input  logic [7:0]       dat_wdata,
    output logic [7:0]       dat_rdata,
    input  logic [15:0]      ap_offset,
    output logic [22:0]      lin_addr,
    output logic             legacy_sel,
    output logic             ext_mode,
    output logic [1:0]       vid_delay,
    output logic [3:0]       clk_div,
    output logic             scale_err
);
    logic [IDX_W-1:0]  idx_q;
    logic [DAT_W-1:0]  mode_q;
    logic [BANK_W-1:0] bank_q;

    crtx_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_we    (idx_we),
        .idx_wdata (idx_wdata),
        .dat_we    (dat_we),
        .dat_wdata (dat_wdata),
        .idx_q     (idx_q),
        .mode_q    (mode_q),
        .bank_q    (bank_q),
        .rdata     (dat_rdata)
    );

    crtx_mode_decode u_dec (
        .mode_q    (mode_q),
        .ext_mode  (ext_mode),
        .vid_delay (vid_delay),
        .clk_div   (clk_div),
        .scale_err (scale_err)
    );

    crtx_aperture u_ap (
        .ext_mode   (ext_mode),
        .bank_q     (bank_q),
        .ap_offset  (ap_offset),
        .lin_addr   (lin_addr),
        .legacy_sel (legacy_sel)
    );
endmodule

// File: rtl/crtx_ext_chk.sv
module crtx_ext_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        dat_we,
    input logic [7:0]  dat_wdata,
    input logic [2:0]  idx_q,
    input logic [7:0]  mode_q,
    input logic [6:0]  bank_q,
    input logic [7:0]  dat_rdata,
    input logic [15:0] ap_offset,
    input logic [22:0] lin_addr,
    input logic        legacy_sel,
    input logic        ext_mode,
    input logic [3:0]  clk_div,
    input logic        scale_err
);
    // R4
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && idx_q == 3'd3) |=> (ext_mode == $past(dat_wdata[7])));

    // R6
    reserved_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scale_err |-> (clk_div == 4'd0));

    // R7
    bank_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == 3'd4) |-> (dat_rdata[7] == 1'b0));

    // R8
    linear_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |-> (!legacy_sel && lin_addr == {bank_q, ap_offset}));

    // R9
    legacy_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode |-> (legacy_sel && lin_addr == {7'd0, ap_offset}));

    // R10
    idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && idx_q != 3'd3 && idx_q != 3'd4) |=> ($stable(mode_q) && $stable(bank_q)));
endmodule

bind crtx_ext_top crtx_ext_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dat_we     (dat_we),
    .dat_wdata  (dat_wdata),
    .idx_q      (idx_q),
    .mode_q     (mode_q),
    .bank_q     (bank_q),
    .dat_rdata  (dat_rdata),
    .ap_offset  (ap_offset),
    .lin_addr   (lin_addr),
    .legacy_sel (legacy_sel),
    .ext_mode   (ext_mode),
    .clk_div    (clk_div),
    .scale_err  (scale_err)
);

// File: tb/sim_crtx_ext_top.sv
`timescale 1ns/1ps
module sim_crtx_ext_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idx_we = 1'b0;
    logic [7:0]  idx_wdata = '0;
    logic        dat_we = 1'b0;
    logic [7:0]  dat_wdata = '0;
    logic [7:0]  dat_rdata;
    logic [15:0] ap_offset = '0;
    logic [22:0] lin_addr;
    logic        legacy_sel;
    logic        ext_mode;
    logic [1:0]  vid_delay;
    logic [3:0]  clk_div;
    logic        scale_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    crtx_ext_top u0 (.*);

    // {mode byte, expected divider, expected reserved flag}
    localparam logic [12:0] VEC [8] = '{
        {8'h00, 4'd1, 1'b0},
        {8'h81, 4'd2, 1'b0},
        {8'h0A, 4'd3, 1'b0},
        {8'h13, 4'd4, 1'b0},
        {8'h9C, 4'd0, 1'b1},
        {8'h05, 4'd6, 1'b0},
        {8'h86, 4'd0, 1'b1},
        {8'hFF, 4'd8, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_idx(input logic [7:0] v);
        @(negedge clk); idx_we = 1'b1; idx_wdata = v;
        @(negedge clk); idx_we = 1'b0;
    endtask

    task automatic put(input logic [7:0] v);
        @(negedge clk); dat_we = 1'b1; dat_wdata = v;
        @(negedge clk); dat_we = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        ap_offset = 16'h4321;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ext", ext_mode, 0);
        check("R1 legacy", legacy_sel, 1);
        check("R1 idx0 read", dat_rdata, 8'h00);
        set_idx(8'h03);
        check("R1 mode reset", dat_rdata, 8'h00);
        set_idx(8'h04);
        check("R1 bank reset", dat_rdata, 8'h00);

        // table: R3 R4 R5 R6
        set_idx(8'h03);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] m;
            m = VEC[i][12:5];
            put(m);
            check("R3 readback", dat_rdata, m);
            check("R4 ext", ext_mode, m[7]);
            check("R5 delay", vid_delay, m[4:3]);
            check("R6 div", clk_div, VEC[i][4:1]);
            check("R6 err", scale_err, VEC[i][0]);
        end

        // R7 bank keeps 7 bits, R9 legacy map
        put(8'h00);
        set_idx(8'h04);
        put(8'hFF);
        check("R7 bank read", dat_rdata, 8'h7F);
        ap_offset = 16'hFFFF;
        #0.5;
        check("R9 lin", lin_addr, 23'h00FFFF);
        check("R9 legacy", legacy_sel, 1);

        // R8 linear map after enabling, first cycle after edge
        set_idx(8'h03);
        put(8'h80);
        check("R4 ext on", ext_mode, 1);
        check("R8 lin", lin_addr, 23'h7FFFFF);
        check("R8 legacy", legacy_sel, 0);
        set_idx(8'h04);
        put(8'h05);
        ap_offset = 16'h1234;
        #0.5;
        check("R8 lin bank5", lin_addr, 23'h051234);

        // R2 aliasing
        set_idx(8'h0B);
        put(8'h07);
        set_idx(8'h03);
        check("R2 alias mode", dat_rdata, 8'h07);
        check("R9 off again", legacy_sel, 1);
        set_idx(8'hFC);
        check("R2 alias bank", dat_rdata, 8'h05);

        // R10 empty slots
        for (int s = 0; s < 8; s++) begin
            if (s != 3 && s != 4) begin
                set_idx(8'(s));
                put(8'hAA);
                check("R10 empty read", dat_rdata, 8'h00);
            end
        end
        set_idx(8'h03);
        check("R10 mode kept", dat_rdata, 8'h07);
        set_idx(8'h04);
        check("R10 bank kept", dat_rdata, 8'h05);

        // R1 reset while running
        set_idx(8'h03);
        put(8'h9B);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 ext after reset", ext_mode, 0);
        check("R1 idx after reset", dat_rdata, 8'h00);
        set_idx(8'h03);
        check("R1 mode after reset", dat_rdata, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule